// File: doc/BRIEF.md
# Ping-Pong Line Buffer Pixel Feeder

This block decouples a slow pixel producer from the fixed-rate scan of a flat panel. A processor or DMA engine hands over one 16-bit word per write strobe, at whatever moments suit it. Each word carries one pixel in 5-6-5 form: red in bits 15:11, green in bits 10:5 and blue in bits 4:0. The panel side reads one pixel per clock across every active line and must never be held up. The feeder keeps two line stores. The writer fills one of them while the display side scans the other, and the two change roles on every line-start pulse from the timing generator.

On the write side the address advances by itself, so the writer only supplies data. On the read side the column count from the timing generator is used directly as the address. That count and the display enable are presented one cycle ahead, so the registered 18-bit pixel lines up with the enable at the panel. Each stored word is widened to 6 bits per colour on its way out. If a line change comes before the writer has filled a whole line, a sticky flag is raised. The display still scans whatever the released store holds and never waits.

Top module: `lbf_line_feeder`

## Requirements
- R1: While reset is high and in the first cycle after it, `pix_out` is 0, `pix_valid` is 0 and `underrun` is 0.
- R2: An output pixel is laid out as red in bits 17:12, green in bits 11:6 and blue in bits 5:0. Red is `{word[15:11],0}`, green is `word[10:5]` and blue is `{word[4:0],0}`.
- R3: After reset, and after each line-start pulse, the k-th accepted write (counting from 0) is stored at column k of the line being filled.
- R4: A line-start pulse swaps the two stores. The line filled before the pulse is the one read after it. Writes made during a line never change the pixels read during that same line.
- R5: `pix_valid` and `pix_out` follow `rd_en` and `rd_col` with exactly one clock of latency.
- R6: A cycle with `rd_en` low produces `pix_out` = 0 and `pix_valid` = 0 in the next cycle, whatever the value of `rd_col`.
- R7: Once LINE_PIX words have been accepted in a line, further write strobes in that line are ignored. They neither wrap around nor change stored columns.
- R8: `underrun` goes to 1 when a line-start pulse arrives with fewer than LINE_PIX words accepted for the line being released, and stays at 1 until reset. Columns that were not rewritten keep their older contents and are displayed as they are.
- R9: A write strobe in the same cycle as a line-start pulse is stored in the store being released and counts toward its fill.
- R10: A read with `rd_en` high and `rd_col` at or above LINE_PIX produces `pix_out` = 0 with `pix_valid` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one pixel word per cycle high |
| wr_data | input | 16 | Pixel word in 5-6-5 form |
| line_start | input | 1 | Line-start pulse that swaps the stores |
| rd_en | input | 1 | Display enable, one cycle ahead of the panel |
| rd_col | input | $clog2(LINE_PIX) | Column to read, one cycle ahead of the panel |
| pix_out | output | 18 | Widened pixel for the panel |
| pix_valid | output | 1 | Registered display enable aligned with `pix_out` |
| underrun | output | 1 | Sticky flag: a line was released before it was full |

## Verification
The bench aims at the edges of the ping-pong handover. It writes and reads in the same cycles, so a design that read the store being filled would show pixels of the next line early. A write is placed in the cycle of a line-start pulse, where a design that dropped it or sent it to the new store would leave column LINE_PIX-1 stale or raise `underrun` by mistake. Extra strobes after a full line would, in a design that wraps its address, overwrite the first columns. A released partial line must raise a flag that stays set, and must still show the older pixels in the columns that were not rewritten. Out-of-range columns and blanking must give zero. Directed colour words that set each channel to all ones catch a misplaced padding bit.

// File: rtl/lbf_pkg.sv
package lbf_pkg;

    // Incoming word and panel pixel widths
    localparam int PIX_IN_W  = 16;
    localparam int CH_OUT_W  = 6;
    localparam int PIX_OUT_W = 3 * CH_OUT_W;

    // Which of the two line stores a role points at
    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;

    // Packed 5-6-5 word as delivered by the writer
    typedef struct packed {
        logic [4:0] r;
        logic [5:0] g;
        logic [4:0] b;
    } rgb565_t;

    // Panel pixel, six bits for each colour
    typedef struct packed {
        logic [CH_OUT_W-1:0] r;
        logic [CH_OUT_W-1:0] g;
        logic [CH_OUT_W-1:0] b;
    } rgb666_t;

    // Red and blue gain a zero LSB; green is already six bits wide
    function automatic rgb666_t widen565(input rgb565_t w);
        rgb666_t o;
        o.r = {w.r, 1'b0};
        o.g = w.g;
        o.b = {w.b, 1'b0};
        return o;
    endfunction

    // The other store
    function automatic bank_e other_bank(input bank_e b);
        return (b == BANK_A) ? BANK_B : BANK_A;
    endfunction

endpackage

// File: rtl/lbf_bank_ctrl.sv
module lbf_bank_ctrl
    import lbf_pkg::*;
#(
    parameter int LINE_PIX = 800,
    localparam int ADDR_W  = $clog2(LINE_PIX),
    localparam int CNT_W   = $clog2(LINE_PIX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              line_start,
    output bank_e             wr_bank,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_accept,
    output logic [CNT_W-1:0]  wr_cnt,
    output logic              underrun
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(LINE_PIX);

    logic [CNT_W-1:0] cnt_after;

    // Strobes past a full line are dropped
    assign wr_accept = wr_en && (wr_cnt < FULL);
    assign wr_addr   = wr_cnt[ADDR_W-1:0];
    // Fill level including a write that lands in the swap cycle
    assign cnt_after = wr_cnt + CNT_W'(wr_accept);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_bank  <= BANK_A;
            wr_cnt   <= '0;
            underrun <= 1'b0;
        end else if (line_start) begin
            wr_bank <= other_bank(wr_bank);
            wr_cnt  <= '0;
            if (cnt_after < FULL) begin
                underrun <= 1'b1;
            end
        end else if (wr_accept) begin
            wr_cnt <= cnt_after;
        end
    end

endmodule

// File: rtl/lbf_line_ram.sv
module lbf_line_ram
    import lbf_pkg::*;
#(
    parameter int LINE_PIX = 800,
    parameter int WORD_W   = PIX_IN_W,
    localparam int ADDR_W  = $clog2(LINE_PIX),
    localparam int N_BANK  = 2
) (
    input  logic              clk,
    input  logic              we,
    input  bank_e             wbank,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  bank_e             rbank,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    logic              r_in_range;
    logic [WORD_W-1:0] bank_rd [N_BANK];

    // Compare one bit wider so a power-of-two line length still works
    assign r_in_range = ({1'b0, raddr} < (ADDR_W + 1)'(LINE_PIX));

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        logic [WORD_W-1:0] mem [LINE_PIX];

        always_ff @(posedge clk) begin
            if (we && (wbank == bank_e'(b))) begin
                mem[waddr] <= wdata;
            end
        end

        assign bank_rd[b] = r_in_range ? mem[raddr] : '0;
    end

    assign rdata = bank_rd[rbank];

endmodule

// File: rtl/lbf_pix_out.sv
module lbf_pix_out
    import lbf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd_en,
    input  rgb565_t              word,
    output logic [PIX_OUT_W-1:0] pix_out,
    output logic                 pix_valid
);

    rgb666_t wide;

    assign wide = widen565(word);

    // One register stage; blanking drives zero
    always_ff @(posedge clk) begin
        if (rst) begin
            pix_out   <= '0;
            pix_valid <= 1'b0;
        end else begin
            pix_valid <= rd_en;
            pix_out   <= rd_en ? wide : '0;
        end
    end

endmodule

// File: rtl/lbf_line_feeder.sv
module lbf_line_feeder
    import lbf_pkg::*;
#(
    parameter int LINE_PIX = 800,
    localparam int ADDR_W  = $clog2(LINE_PIX),
    localparam int CNT_W   = $clog2(LINE_PIX + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [PIX_IN_W-1:0]  wr_data,
    input  logic                 line_start,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_col,
    output logic [PIX_OUT_W-1:0] pix_out,
    output logic                 pix_valid,
    output logic                 underrun
);

    bank_e               wr_bank;
    bank_e               rd_bank;
    logic [ADDR_W-1:0]   wr_addr;
    logic                wr_accept;
    logic [CNT_W-1:0]    wr_cnt;
    logic [PIX_IN_W-1:0] rd_word;

    lbf_bank_ctrl #(.LINE_PIX(LINE_PIX)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .line_start (line_start),
        .wr_bank    (wr_bank),
        .wr_addr    (wr_addr),
        .wr_accept  (wr_accept),
        .wr_cnt     (wr_cnt),
        .underrun   (underrun)
    );

    // Display always scans the store the writer is not filling
    assign rd_bank = other_bank(wr_bank);

    lbf_line_ram #(.LINE_PIX(LINE_PIX), .WORD_W(PIX_IN_W)) u_ram (
        .clk   (clk),
        .we    (wr_accept),
        .wbank (wr_bank),
        .waddr (wr_addr),
        .wdata (wr_data),
        .rbank (rd_bank),
        .raddr (rd_col),
        .rdata (rd_word)
    );

    lbf_pix_out u_out (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .word      (rgb565_t'(rd_word)),
        .pix_out   (pix_out),
        .pix_valid (pix_valid)
    );

endmodule

// File: rtl/lbf_line_feeder_chk.sv
module lbf_line_feeder_chk #(
    parameter int LINE_PIX = 800,
    localparam int ADDR_W  = $clog2(LINE_PIX),
    localparam int CNT_W   = $clog2(LINE_PIX + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              line_start,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_col,
    input logic [17:0]       pix_out,
    input logic              pix_valid,
    input logic              underrun,
    input logic              wr_bank,
    input logic [CNT_W-1:0]  wr_cnt
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pix_out == '0 && !pix_valid && !underrun));

    // R2
    pad_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_out[12] == 1'b0 && pix_out[0] == 1'b0));

    // R3
    restart_addr_chk: assert property (@(posedge clk) disable iff (rst)
        line_start |=> (wr_cnt == '0));

    // R4
    swap_chk: assert property (@(posedge clk) disable iff (rst)
        line_start |=> (wr_bank != $past(wr_bank)));

    // R4
    hold_bank_chk: assert property (@(posedge clk) disable iff (rst)
        !line_start |=> $stable(wr_bank));

    // R5
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> pix_valid);

    // R6
    blank_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (!pix_valid && pix_out == '0));

    // R7
    fill_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_cnt <= CNT_W'(LINE_PIX)));

    // R7
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_cnt == CNT_W'(LINE_PIX) && wr_en && !line_start) |=> (wr_cnt == CNT_W'(LINE_PIX)));

    // R8
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);

    // R8
    underrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> $past(line_start));

    // R10
    col_range_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && ({1'b0, rd_col} >= (ADDR_W + 1)'(LINE_PIX))) |=> (pix_out == '0));

endmodule

bind lbf_line_feeder lbf_line_feeder_chk #(.LINE_PIX(LINE_PIX)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .line_start (line_start),
    .rd_en      (rd_en),
    .rd_col     (rd_col),
    .pix_out    (pix_out),
    .pix_valid  (pix_valid),
    .underrun   (underrun),
    .wr_bank    (wr_bank),
    .wr_cnt     (wr_cnt)
);

// File: tb/test_lbf_line_feeder.sv
`timescale 1ns/1ps
module test_lbf_line_feeder;

    localparam int LINE = 800;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        line_start = 1'b0;
    logic        rd_en = 1'b0;
    logic [9:0]  rd_col = '0;
    logic [17:0] pix_out;
    logic        pix_valid;
    logic        underrun;

    int n_chk  = 0;
    int n_fail = 0;

    // Requirement-level model: two line images, fill count, flag
    logic [15:0] mdl [2][LINE];
    int          wsel = 0;
    int          cnt  = 0;
    bit          under_exp = 1'b0;

    always #2 clk = ~clk;

    lbf_line_feeder #(.LINE_PIX(LINE)) i_lbf_line_feeder (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .line_start (line_start),
        .rd_en      (rd_en),
        .rd_col     (rd_col),
        .pix_out    (pix_out),
        .pix_valid  (pix_valid),
        .underrun   (underrun)
    );

    function automatic logic [17:0] exp_px(input logic [15:0] w);
        return {w[15:11], 1'b0, w[10:5], w[4:0], 1'b0};
    endfunction

    task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: apply inputs, tick, compare outputs with the model
    task automatic step(input bit we, input logic [15:0] wd, input bit ls,
                        input bit re, input int rc, input string tag);
        logic [17:0] e;
        int rs;
        rs = 1 - wsel;
        e  = (re && rc < LINE) ? exp_px(mdl[rs][rc]) : 18'd0;
        wr_en = we; wr_data = wd; line_start = ls; rd_en = re; rd_col = rc[9:0];
        @(posedge clk); #1;
        wr_en = 1'b0; line_start = 1'b0; rd_en = 1'b0;
        if (we && cnt < LINE) begin
            mdl[wsel][cnt] = wd;
            cnt++;
        end
        if (ls) begin
            if (cnt < LINE) under_exp = 1'b1;
            wsel = 1 - wsel;
            cnt  = 0;
        end
        check(tag, pix_out, e);
        check("R5 valid", {17'd0, pix_valid}, {17'd0, re});
        check("R8 underrun", {17'd0, underrun}, {17'd0, under_exp});
    endtask

    // Fill the rest of the line with random words and gaps; optional reads
    task automatic fill_line(input bit with_reads, input string tag);
        while (cnt < LINE) begin
            bit we;
            bit re;
            we = ($urandom % 4) != 0;
            re = with_reads && (($urandom % 2) == 1);
            step(we, 16'($urandom), 1'b0, re, int'($urandom % LINE), tag);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1;
        check("R1 pix_out", pix_out, 18'd0);
        check("R1 pix_valid", {17'd0, pix_valid}, 18'd0);
        check("R1 underrun", {17'd0, underrun}, 18'd0);
        rst = 1'b0;
        @(posedge clk); #1;
        check("R1 pix_out after release", pix_out, 18'd0);

        // Line A into store 0: directed colour words first
        step(1'b1, 16'hFFFF, 1'b0, 1'b0, 0, "R6");
        step(1'b1, 16'hF800, 1'b0, 1'b0, 0, "R6");
        step(1'b1, 16'h07E0, 1'b0, 1'b0, 0, "R6");
        step(1'b1, 16'h001F, 1'b0, 1'b0, 0, "R6");
        step(1'b1, 16'h0821, 1'b0, 1'b0, 0, "R6");
        fill_line(1'b0, "R6");
        step(1'b0, 16'h0, 1'b1, 1'b0, 0, "R4");

        // Colour layout on the directed columns
        for (int c = 0; c < 5; c++) step(1'b0, 16'h0, 1'b0, 1'b1, c, "R2");
        // Full sequential scan: write order maps to column order
        for (int c = 0; c < LINE; c++) step(1'b0, 16'h0, 1'b0, 1'b1, c, "R3");

        // Line B into store 1 while line A is scanned
        fill_line(1'b1, "R4");
        // Extra strobes on a full line
        for (int k = 0; k < 6; k++) step(1'b1, 16'hA5A5, 1'b0, 1'b1, k, "R7");
        step(1'b0, 16'h0, 1'b1, 1'b0, 0, "R4");
        for (int c = 0; c < 6; c++) step(1'b0, 16'h0, 1'b0, 1'b1, c, "R7");
        for (int c = LINE - 4; c < LINE; c++) step(1'b0, 16'h0, 1'b0, 1'b1, c, "R7");

        // Line C into store 0: last word lands in the swap cycle
        while (cnt < LINE - 1) step(1'b1, 16'($urandom), 1'b0, 1'b1, int'($urandom % LINE), "R4");
        step(1'b1, 16'h5AC3, 1'b1, 1'b1, LINE - 1, "R9");
        step(1'b0, 16'h0, 1'b0, 1'b1, LINE - 1, "R9");
        for (int c = 0; c < LINE; c += 7) step(1'b0, 16'h0, 1'b0, 1'b1, c, "R9");

        // Line D into store 1: only 300 words, then release
        while (cnt < 300) step(1'b1, 16'($urandom), 1'b0, 1'b0, 0, "R6");
        step(1'b0, 16'h0, 1'b1, 1'b0, 0, "R8");
        for (int c = 0; c < LINE; c++) step(1'b0, 16'h0, 1'b0, 1'b1, c, "R8");

        // Line E full: flag must stay set
        fill_line(1'b1, "R4");
        step(1'b0, 16'h0, 1'b1, 1'b0, 0, "R8");
        for (int k = 0; k < 10; k++) step(1'b0, 16'h0, 1'b0, 1'b1, int'($urandom % LINE), "R8");

        // Columns beyond the line
        step(1'b0, 16'h0, 1'b0, 1'b1, LINE, "R10");
        step(1'b0, 16'h0, 1'b0, 1'b1, 1023, "R10");
        for (int k = 0; k < 8; k++) step(1'b0, 16'h0, 1'b0, 1'b1, LINE + int'($urandom % 224), "R10");

        // Blanking with a valid column on the bus
        for (int k = 0; k < 8; k++) step(1'b0, 16'h0, 1'b0, 1'b0, int'($urandom % LINE), "R6");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule